// File: doc/BRIEF.md
# SDRAM power-up initialization sequencer

This block drives the command pins of a low-power single-data-rate SDRAM from reset until the memory can accept normal traffic. While the memory clock is not yet reported stable it holds the chip deselected. Once the clock-stable input is high, it drives NOP for a fixed stabilization time. It then sends one precharge to all banks, exactly two auto-refresh commands and one mode register load, and leaves the required number of NOP cycles after each of them.

The stabilization time is given in microseconds and the clock frequency in hertz. The block rounds the product up to a whole number of cycles. The precharge, refresh and mode-load recovery gaps are cycle-count parameters. The mode word is built from burst length, burst type and CAS latency parameters. When the last gap has elapsed, `initDone` goes high and stays high until the next reset. Only then may a downstream memory controller take over the pins.

All pin outputs are registered. A command decided by the control logic appears on the pins one clock later.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and in the first cycle after it, the pins show the deselect code (`sdramCsN` = 1, the other three command pins 1), `sdramCke` = 1, `initDone` = 0, and address and bank are 0.
- R2: Before precharge has been issued, every cycle in which `clkStable` was low on the previous edge shows deselect on the pins. A low pulse on `clkStable` during the wait restarts the stabilization count from zero.
- R3: Precharge is preceded by exactly WAIT = ceil(CLK_FREQ_HZ × STABLE_US / 1e6) consecutive NOP cycles ({CsN,RasN,CasN,WeN} = 0111), counted from the first edge that saw `clkStable` high.
- R4: Precharge is encoded as 0010 on {CsN,RasN,CasN,WeN}, with address bit 10 = 1, all other address bits 0 and bank 0. It is issued once.
- R5: The first auto-refresh (0001) follows precharge after exactly TRP_CYC NOP cycles.
- R6: The second auto-refresh follows the first after exactly TRFC_CYC NOP cycles. No third refresh is issued.
- R7: The mode load (0000) follows the second refresh after exactly TRFC_CYC NOP cycles. Its address carries the mode word: burst length code in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, zeros elsewhere. Its bank is 0.
- R8: `initDone` rises exactly TMRD_CYC NOP cycles after the mode load cycle. It then stays high with NOP on the pins until reset.
- R9: `sdramCke` is 1 in every cycle.
- R10: `clkStable` is ignored once precharge has been issued. Dropping it does not change the later commands or gaps.
- R11: A reset in the middle of the sequence returns the pins to deselect at once. After release, the whole sequence starts again from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| clkStable | input | 1 | High when the memory clock is within its limits |
| sdramCsN | output | 1 | Chip select, active low |
| sdramRasN | output | 1 | Row strobe, active low |
| sdramCasN | output | 1 | Column strobe, active low |
| sdramWeN | output | 1 | Write enable, active low |
| sdramCke | output | 1 | Clock enable, held high |
| sdramAddr | output | ADDR_W | Address bus (bit 10 selects all banks on precharge, mode word on mode load) |
| sdramBank | output | BANK_W | Bank select, zero throughout |
| initDone | output | 1 | High once initialization is complete |

## Verification
On every cycle the assertions check the command order and its gaps: the NOP run before precharge, each refresh and the mode load, the refresh count, the mode word, and that `initDone` is sticky and rises only after the last gap. They also check the deselect response to a low `clkStable` before precharge, and that CKE stays high. Only the bench scenarios show that a `clkStable` dropout restarts the wait rather than pausing it, that `clkStable` has no effect after precharge, that a reset mid-sequence gives a full replay, and that the wait count rounds up for a frequency that does not divide evenly.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_INH = 4'b1111;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  localparam int unsigned NUM_REFRESH = 2;
  localparam int unsigned ALL_BANK_BIT = 10;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_RP, ST_REF, ST_RFC, ST_LMR, ST_MRD, ST_DONE
  } initState_t;

  // One strobe per cycle from control to the pin datapath
  typedef struct packed {
    logic inhibit;
    logic nop;
    logic pre;
    logic refresh;
    logic lmr;
    logic done;
  } cmdStrobe_t;

  // Stabilization time in cycles, rounded up
  function automatic int unsigned waitCycles(input int unsigned freqHz, input int unsigned us);
    longint unsigned prod;
    prod = longint'(freqHz) * longint'(us);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  function automatic int unsigned maxOf4(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [31:0] modeWord(input logic [2:0] burstLen, input logic burstType,
                                           input logic [2:0] casLat);
    return {25'b0, casLat, burstType, burstLen};
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
`timescale 1ns/1ps
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 5000,
  parameter int unsigned TRP_CYC  = 3,
  parameter int unsigned TRFC_CYC = 8,
  parameter int unsigned TMRD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clkStable,
  output cmdStrobe_t strobe
);

  localparam int unsigned MAX_CNT = maxOf4(WAIT_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam int unsigned REF_W   = $clog2(NUM_REFRESH + 1);

  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LAST   = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] RFC_LAST  = CNT_W'(TRFC_CYC - 1);
  localparam logic [CNT_W-1:0] MRD_LAST  = CNT_W'(TMRD_CYC - 1);
  localparam logic [REF_W-1:0] REF_ALL   = REF_W'(NUM_REFRESH);

  initState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_WAIT;
      cnt    <= '0;
      refIdx <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          // a dropout restarts the stabilization count
          if (!clkStable) begin
            cnt <= '0;
          end else if (cnt == WAIT_LAST) begin
            cnt   <= '0;
            state <= ST_PRE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PRE: state <= ST_RP;
        ST_RP: begin
          if (cnt == RP_LAST) begin
            cnt   <= '0;
            state <= ST_REF;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REF: begin
          refIdx <= refIdx + 1'b1;
          state  <= ST_RFC;
        end
        ST_RFC: begin
          if (cnt == RFC_LAST) begin
            cnt   <= '0;
            state <= (refIdx == REF_ALL) ? ST_LMR : ST_REF;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LMR: state <= ST_MRD;
        ST_MRD: begin
          if (cnt == MRD_LAST) begin
            cnt   <= '0;
            state <= ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    case (state)
      ST_WAIT: begin
        strobe.inhibit = !clkStable;
        strobe.nop     = clkStable;
      end
      ST_PRE:                strobe.pre     = 1'b1;
      ST_REF:                strobe.refresh = 1'b1;
      ST_LMR:                strobe.lmr     = 1'b1;
      ST_RP, ST_RFC, ST_MRD: strobe.nop     = 1'b1;
      default: begin
        strobe.nop  = 1'b1;
        strobe.done = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sdram_init_pins.sv
`timescale 1ns/1ps
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  cmdStrobe_t        strobe,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              doneFlag
);

  localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << ALL_BANK_BIT;

  logic [3:0] cmdNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    if (strobe.inhibit) begin
      cmdNext = CMD_INH;
    end else if (strobe.pre) begin
      cmdNext  = CMD_PRE;
      addrNext = PRE_ALL_ADDR;
    end else if (strobe.refresh) begin
      cmdNext = CMD_REF;
    end else if (strobe.lmr) begin
      cmdNext  = CMD_LMR;
      addrNext = MODE_WORD;
    end else if (strobe.nop) begin
      cmdNext = CMD_NOP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {csN, rasN, casN, weN} <= CMD_INH;
      cke      <= 1'b1;
      addr     <= '0;
      bank     <= '0;
      doneFlag <= 1'b0;
    end else begin
      {csN, rasN, casN, weN} <= cmdNext;
      cke      <= 1'b1;
      addr     <= addrNext;
      bank     <= '0;
      doneFlag <= doneFlag | strobe.done;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ    = 50_000_000,
  parameter int unsigned STABLE_US      = 100,
  parameter int unsigned TRP_CYC        = 3,
  parameter int unsigned TRFC_CYC       = 8,
  parameter int unsigned TMRD_CYC       = 2,
  parameter int unsigned ADDR_W         = 13,
  parameter int unsigned BANK_W         = 2,
  parameter logic [2:0]  BURST_LEN_CODE = 3'd3,
  parameter logic        BURST_TYPE     = 1'b0,
  parameter logic [2:0]  CAS_LAT        = 3'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkStable,
  output logic              sdramCsN,
  output logic              sdramRasN,
  output logic              sdramCasN,
  output logic              sdramWeN,
  output logic              sdramCke,
  output logic [ADDR_W-1:0] sdramAddr,
  output logic [BANK_W-1:0] sdramBank,
  output logic              initDone
);

  localparam int unsigned WAIT_CYC = waitCycles(CLK_FREQ_HZ, STABLE_US);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'(modeWord(BURST_LEN_CODE, BURST_TYPE, CAS_LAT));

  cmdStrobe_t strobe;

  sdram_init_ctrl #(
    .WAIT_CYC (WAIT_CYC),
    .TRP_CYC  (TRP_CYC),
    .TRFC_CYC (TRFC_CYC),
    .TMRD_CYC (TMRD_CYC)
  ) ctrlI (
    .clk       (clk),
    .rst       (rst),
    .clkStable (clkStable),
    .strobe    (strobe)
  );

  sdram_init_pins #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .MODE_WORD (MODE_WORD)
  ) pinsI (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .csN      (sdramCsN),
    .rasN     (sdramRasN),
    .casN     (sdramCasN),
    .weN      (sdramWeN),
    .cke      (sdramCke),
    .addr     (sdramAddr),
    .bank     (sdramBank),
    .doneFlag (initDone)
  );

endmodule

// File: rtl/sdram_init_chk.sv
`timescale 1ns/1ps
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 5000,
  parameter int unsigned TRP_CYC  = 3,
  parameter int unsigned TRFC_CYC = 8,
  parameter int unsigned TMRD_CYC = 2,
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned BANK_W   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              clkStable,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic              cke,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              initDone
);

  localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << ALL_BANK_BIT;

  logic [3:0]  cmd;
  logic [31:0] nopRun;
  logic [2:0]  preCnt, refCnt, lmrCnt;

  assign cmd = {csN, rasN, casN, weN};

  // consecutive NOP cycles seen before the current one, and command tallies
  always_ff @(posedge clk) begin
    if (rst) begin
      nopRun <= '0;
      preCnt <= '0;
      refCnt <= '0;
      lmrCnt <= '0;
    end else begin
      if (cmd == CMD_NOP) begin
        if (nopRun != '1) nopRun <= nopRun + 1'b1;
      end else begin
        nopRun <= '0;
      end
      if (cmd == CMD_PRE && preCnt != 3'd7) preCnt <= preCnt + 1'b1;
      if (cmd == CMD_REF && refCnt != 3'd7) refCnt <= refCnt + 1'b1;
      if (cmd == CMD_LMR && lmrCnt != 3'd7) lmrCnt <= lmrCnt + 1'b1;
    end
  end

  AST_RESET_DESELECT: assert property (@(posedge clk) rst |=> (csN && !initDone)); // R1
  AST_DESELECT_UNSTABLE: assert property (@(posedge clk) disable iff (rst)
    (!clkStable && preCnt == 0 && cmd != CMD_PRE) |=> (csN || cmd == CMD_PRE)); // R2
  AST_WAIT_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> (preCnt == 0 && nopRun == WAIT_CYC)); // R3
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> (addr == PRE_ALL_ADDR && bank == '0)); // R4
  AST_FIRST_REF_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF && refCnt == 0) |-> (preCnt == 1 && nopRun == TRP_CYC)); // R5
  AST_SECOND_REF_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF && refCnt != 0) |-> (refCnt == 1 && nopRun == TRFC_CYC)); // R6
  AST_LMR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LMR) |-> (preCnt == 1 && refCnt == 2 && lmrCnt == 0 && nopRun == TRFC_CYC)); // R7
  AST_LMR_WORD: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LMR) |-> (addr == MODE_WORD && bank == '0)); // R7
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
    $rose(initDone) |-> (lmrCnt == 1 && nopRun == TMRD_CYC)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone); // R8
  AST_NOP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    initDone |-> (cmd == CMD_NOP)); // R8
  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (rst) cke); // R9

endmodule

bind sdram_init_seq sdram_init_chk #(
  .WAIT_CYC  (WAIT_CYC),
  .TRP_CYC   (TRP_CYC),
  .TRFC_CYC  (TRFC_CYC),
  .TMRD_CYC  (TMRD_CYC),
  .ADDR_W    (ADDR_W),
  .BANK_W    (BANK_W),
  .MODE_WORD (MODE_WORD)
) chkI (
  .clk       (clk),
  .rst       (rst),
  .clkStable (clkStable),
  .csN       (sdramCsN),
  .rasN      (sdramRasN),
  .casN      (sdramCasN),
  .weN       (sdramWeN),
  .cke       (sdramCke),
  .addr      (sdramAddr),
  .bank      (sdramBank),
  .initDone  (initDone)
);

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

  localparam int TRP  = 3;
  localparam int TRFC = 8;
  localparam int TMRD = 2;
  localparam int MAIN_WAIT  = 5000; // 50 MHz x 100 us
  localparam int ROUND_WAIT = 100;  // 33.333333 MHz x 3 us = 99.999999, rounded up
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;
  localparam int EXP_MODE = (3 << 4) | (0 << 3) | 3;
  localparam int PRE_ADDR = 1 << 10;

  typedef struct packed {
    logic [3:0] code;
    logic [31:0] gap;
  } step_t;

  // commands after precharge: each with the NOP gap that must precede it
  localparam step_t STEPS [3] = '{
    '{code: REF, gap: TRP},
    '{code: REF, gap: TRFC},
    '{code: LMR, gap: TRFC}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkStable = 1'b0;
  logic useRound = 1'b0;

  logic dCs, dRas, dCas, dWe, dCke, dDone;
  logic [12:0] dAddr;
  logic [1:0]  dBank;
  logic rCs, rRas, rCas, rWe, rCke, rDone;
  logic [12:0] rAddr;
  logic [1:0]  rBank;

  logic [3:0]  oCmd;
  logic [12:0] oAddr;
  logic [1:0]  oBank;
  logic        oDone;

  int checks = 0;
  int errors = 0;
  int ckeBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .CLK_FREQ_HZ(50_000_000), .STABLE_US(100),
    .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD)
  ) dut_i (
    .clk(clk), .rst(rst), .clkStable(clkStable),
    .sdramCsN(dCs), .sdramRasN(dRas), .sdramCasN(dCas), .sdramWeN(dWe),
    .sdramCke(dCke), .sdramAddr(dAddr), .sdramBank(dBank), .initDone(dDone)
  );

  sdram_init_seq #(
    .CLK_FREQ_HZ(33_333_333), .STABLE_US(3),
    .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD)
  ) round_i (
    .clk(clk), .rst(rst), .clkStable(clkStable),
    .sdramCsN(rCs), .sdramRasN(rRas), .sdramCasN(rCas), .sdramWeN(rWe),
    .sdramCke(rCke), .sdramAddr(rAddr), .sdramBank(rBank), .initDone(rDone)
  );

  always_comb begin
    oCmd  = useRound ? {rCs, rRas, rCas, rWe} : {dCs, dRas, dCas, dWe};
    oAddr = useRound ? rAddr : dAddr;
    oBank = useRound ? rBank : dBank;
    oDone = useRound ? rDone : dDone;
  end

  // R9: clock enable watched on every cycle of both instances
  always @(negedge clk) if (!dCke || !rCke) ckeBad++;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string stepReq(input int i);
    case (i)
      0: return "R5";
      1: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic countNops(output int n);
    n = 0;
    @(negedge clk);
    while (oCmd == NOP && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic resetPulse();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // walks the command table after the stabilization wait
  task automatic runSeq(input string waitReq, input int expWait, input bit dropAfterPre);
    int n;
    int bad;
    countNops(n);
    check(waitReq, "NOP cycles before precharge", n, expWait);
    check("R4", "precharge code", oCmd, PRE);
    check("R4", "precharge address", oAddr, PRE_ADDR);
    check("R4", "precharge bank", oBank, 0);
    if (dropAfterPre) clkStable = 1'b0;
    for (int i = 0; i < 3; i++) begin
      countNops(n);
      check(stepReq(i), "NOP gap", n, STEPS[i].gap);
      check(stepReq(i), "command code", oCmd, STEPS[i].code);
    end
    check("R7", "mode word", oAddr, EXP_MODE);
    check("R7", "mode bank", oBank, 0);
    n = 0;
    bad = 0;
    @(negedge clk);
    while (!oDone && n < 100) begin
      if (oCmd != NOP) bad++;
      n++;
      @(negedge clk);
    end
    check("R8", "cycles from mode load to done", n, TMRD);
    for (int i = 0; i < 20; i++) begin
      if (!oDone || oCmd != NOP) bad++;
      @(negedge clk);
    end
    check("R8", "done sticky with NOP", bad, 0);
    if (dropAfterPre) check("R10", "done with clock-stable low", oDone, 1);
  endtask

  initial begin
    int n;
    int bad;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "command in reset", oCmd, 4'b1111);
    check("R1", "cke in reset", dCke, 1);
    check("R1", "done in reset", dDone, 0);
    check("R1", "address in reset", dAddr, 0);
    check("R1", "bank in reset", dBank, 0);

    // R2: deselect while the clock is unstable, then the full sequence
    rst = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!dCs) bad++;
    end
    check("R2", "deselect while unstable", bad, 0);
    clkStable = 1'b1;
    runSeq("R3", MAIN_WAIT, 1'b0);

    // R2 restart after a dropout, then R10 dropout after precharge
    resetPulse();
    repeat (100) @(negedge clk);
    clkStable = 1'b0;
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      if (!dCs) bad++;
      @(negedge clk);
    end
    check("R2", "deselect during dropout", bad, 0);
    clkStable = 1'b1;
    runSeq("R2", MAIN_WAIT, 1'b1);

    // R11: reset after the first refresh, then a full replay
    clkStable = 1'b1;
    resetPulse();
    countNops(n);
    check("R11", "first pass precharge", oCmd, PRE);
    countNops(n);
    check("R11", "first pass refresh", oCmd, REF);
    rst = 1'b1;
    @(negedge clk);
    check("R11", "deselect on mid reset", oCmd, 4'b1111);
    check("R11", "done low on mid reset", oDone, 0);
    @(negedge clk);
    rst = 1'b0;
    runSeq("R11", MAIN_WAIT, 1'b0);

    // R3: rounding up of the wait count on the second instance
    useRound = 1'b1;
    resetPulse();
    runSeq("R3", ROUND_WAIT, 1'b0);

    check("R9", "cycles with cke low", ckeBad, 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule